// File: doc/BRIEF.md
# RTC Interrupt Emulation Unit

This unit drives one one-shot channel of a free-running 32-bit timer and uses it to rebuild the three classic real-time-clock interrupt sources. The sources are a once-per-second update event, a time-of-day alarm and a periodic interrupt at a power-of-two rate. Each time the channel matches, the unit re-arms the comparator. At that point it compares the current hours, minutes and seconds, which a separate time-keeping block supplies, against its own stored state. It then emits one packed interrupt word.

Update and alarm detection poll a base tick of 64 Hz. A periodic rate at or below 64 Hz is made by dividing that tick. A faster rate swaps the re-arm interval for one period of the requested rate. When interrupt service falls behind, the comparator is stepped forward until it is ahead of the counter again. The skipped steps are reported as lost events, and they are credited to the periodic divider.

Top module: `rtc_emu_unit`

## Requirements
- R1: The base re-arm interval is CNT_HZ/64 counter ticks. It is used whenever the periodic source is off or its rate is 64 Hz or lower.
- R2: The periodic rate is 2^k Hz, with k taken from `rate_log2_i`. For k ≤ 6 the periodic flag fires once every 2^(6-k) ticks. The divider adds 1 plus that tick's lost-event count, fires when the total reaches the limit, and then clears.
- R3: For k > 6 the re-arm interval is CNT_HZ >> k (at least 1), and the periodic flag fires on every tick.
- R4: The update flag is set on a tick whose seconds value differs from the seconds value stored at the last update event. The stored value starts at 0 after reset and is refreshed whenever the flag fires.
- R5: The alarm flag is set on a tick where hours, minutes and seconds all equal the alarm inputs.
- R6: On a tick the comparator is advanced by the interval. It keeps advancing while the signed 32-bit difference (counter − comparator) is positive. Advances beyond the first are reported on `lost_o`, which saturates at its maximum.
- R7: A tick that arrives with no source enabled clears `chan_en_o` and leaves the comparator unchanged. When the enabled-source set goes from empty to non-empty, the comparator is loaded with counter + interval and the channel is enabled on the next edge.
- R8: When at least one flag is set, `irq_stb_o` pulses for one cycle. The word on `irq_word_o` then has 0x01 in bits 15:8, the pending bit 0x80 set, the flags in bits 6:4 and zeros in bits 3:0. A tick with no flag produces no strobe. Reset clears all outputs.
- R9: The source enable mask uses the flag bit positions: 0x40 periodic, 0x20 alarm, 0x10 update. All other mask bits are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| tick_i | input | 1 | Timer channel match pulse |
| count_i | input | 32 | Current timer counter value |
| hour_i | input | 8 | Current hours |
| min_i | input | 8 | Current minutes |
| sec_i | input | 8 | Current seconds |
| alm_hour_i | input | 8 | Alarm hours |
| alm_min_i | input | 8 | Alarm minutes |
| alm_sec_i | input | 8 | Alarm seconds |
| src_en_i | input | 8 | Source enable mask (0x40/0x20/0x10) |
| rate_log2_i | input | 4 | Periodic rate exponent k, rate = 2^k Hz |
| cmp_o | output | 32 | Comparator value for the channel |
| chan_en_o | output | 1 | Channel enable (one-shot, 32-bit compare) |
| lost_o | output | 8 | Lost events at the latest tick |
| irq_word_o | output | 16 | Packed interrupt flag word |
| irq_stb_o | output | 1 | Interrupt word strobe |

## Verification
The hardest condition to produce is a late tick, where the counter has already run several intervals past the comparator. This case covers both the catch-up loop and the lost-event credit to the periodic divider. The bench produces it by presenting a counter value several intervals beyond its modelled comparator. It chooses values that land just short of an interval boundary, and also values that straddle the 32-bit wrap. It then checks the new comparator, the lost count, and whether the divider fires early. Every slow periodic rate is swept through its full divide cycle.

// File: rtl/rtc_emu_pkg.sv
package rtc_emu_pkg;
    localparam int TW        = 32;
    localparam int BASE_LOG2 = 6;   // 64 Hz polling tick
    localparam int LIM_W     = BASE_LOG2 + 1;

    localparam logic [7:0] FLG_PEND = 8'h80;
    localparam logic [7:0] FLG_PER  = 8'h40;
    localparam logic [7:0] FLG_ALM  = 8'h20;
    localparam logic [7:0] FLG_UPD  = 8'h10;

    typedef struct packed {
        logic [7:0] hour;
        logic [7:0] min;
        logic [7:0] sec;
    } tod_t;

    typedef struct packed {
        logic per;
        logic alm;
        logic upd;
    } flags_t;

    function automatic logic [TW-1:0] fast_interval(input logic [TW-1:0] hz,
                                                    input logic [3:0] k);
        logic [TW-1:0] v;
        v = hz >> k;
        return (v == '0) ? {{(TW-1){1'b0}}, 1'b1} : v;
    endfunction

    function automatic logic [15:0] pack_word(input flags_t f);
        return {8'h01, FLG_PEND | (f.per ? FLG_PER : 8'h00)
                                | (f.alm ? FLG_ALM : 8'h00)
                                | (f.upd ? FLG_UPD : 8'h00)};
    endfunction
endpackage

// File: rtl/rtc_interval_sel.sv
module rtc_interval_sel
    import rtc_emu_pkg::*;
#(
    parameter int CNT_HZ = 32768
) (
    input  logic              per_en,
    input  logic [3:0]        rate_log2,
    output logic [TW-1:0]     delta,
    output logic [LIM_W-1:0]  limit
);
    localparam logic [TW-1:0] HZ_V     = TW'(CNT_HZ);
    localparam logic [TW-1:0] BASE_DLT = TW'(CNT_HZ >> BASE_LOG2);

    logic fast;
    assign fast = per_en && (rate_log2 > 4'(BASE_LOG2));

    always_comb begin
        if (fast) begin
            delta = fast_interval(HZ_V, rate_log2);
            limit = LIM_W'(1);
        end else begin
            delta = BASE_DLT;
            limit = LIM_W'(1) << (3'(BASE_LOG2) - rate_log2[2:0]);
        end
    end
endmodule

// File: rtl/rtc_rearm.sv
module rtc_rearm
    import rtc_emu_pkg::*;
#(
    parameter int LOST_W = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              tick,
    input  logic [TW-1:0]     count,
    input  logic              any_src,
    input  logic [TW-1:0]     delta,
    output logic [TW-1:0]     cmp,
    output logic              chan_en,
    output logic              busy,
    output logic              done,
    output logic [LOST_W-1:0] lost
);
    localparam logic [LOST_W-1:0] LOST_MAX = '1;

    logic [TW-1:0]     step_q;
    logic [LOST_W-1:0] run_q;
    logic              any_q;
    logic              behind;

    assign behind = $signed(count - cmp) > 0;

    always_ff @(posedge clk) begin
        if (rst) begin
            cmp     <= '0;
            chan_en <= 1'b0;
            busy    <= 1'b0;
            done    <= 1'b0;
            lost    <= '0;
            step_q  <= '0;
            run_q   <= '0;
            any_q   <= 1'b0;
        end else begin
            done  <= 1'b0;
            any_q <= any_src;
            if (busy) begin
                if (behind) begin
                    cmp <= cmp + step_q;
                    if (run_q != LOST_MAX) run_q <= run_q + 1'b1;
                end else begin
                    busy <= 1'b0;
                    done <= 1'b1;
                    lost <= run_q;
                end
            end else if (tick && chan_en) begin
                if (!any_src) begin
                    chan_en <= 1'b0;
                end else begin
                    cmp    <= cmp + delta;
                    step_q <= delta;
                    run_q  <= '0;
                    busy   <= 1'b1;
                end
            end else if (any_src && !any_q) begin
                cmp     <= count + delta;
                chan_en <= 1'b1;
            end
        end
    end
endmodule

// File: rtl/rtc_flag_eval.sv
module rtc_flag_eval
    import rtc_emu_pkg::*;
#(
    parameter int LOST_W = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              done,
    input  logic [LOST_W-1:0] lost,
    input  logic [7:0]        src_en,
    input  tod_t              now,
    input  tod_t              alarm,
    input  logic [LIM_W-1:0]  limit,
    output logic [15:0]       word,
    output logic              stb
);
    localparam int SUM_W = LOST_W + 2;

    logic [7:0]       prev_sec_q;
    logic [LIM_W-1:0] pcnt_q;
    logic [SUM_W-1:0] sum;
    flags_t           f;

    assign sum   = SUM_W'(pcnt_q) + SUM_W'(lost) + SUM_W'(1);
    assign f.upd = src_en[4] && (now.sec != prev_sec_q);
    assign f.alm = src_en[5] && (now == alarm);
    assign f.per = src_en[6] && (sum >= SUM_W'(limit));

    always_ff @(posedge clk) begin
        if (rst) begin
            prev_sec_q <= '0;
            pcnt_q     <= '0;
            word       <= '0;
            stb        <= 1'b0;
        end else begin
            stb <= 1'b0;
            if (done) begin
                if (f.upd) prev_sec_q <= now.sec;
                if (src_en[6]) pcnt_q <= f.per ? '0 : sum[LIM_W-1:0];
                if (f.upd || f.alm || f.per) begin
                    word <= pack_word(f);
                    stb  <= 1'b1;
                end
            end
        end
    end
endmodule

// File: rtl/rtc_emu_unit.sv
module rtc_emu_unit
    import rtc_emu_pkg::*;
#(
    parameter int CNT_HZ = 32768,
    parameter int LOST_W = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              tick_i,
    input  logic [31:0]       count_i,
    input  logic [7:0]        hour_i,
    input  logic [7:0]        min_i,
    input  logic [7:0]        sec_i,
    input  logic [7:0]        alm_hour_i,
    input  logic [7:0]        alm_min_i,
    input  logic [7:0]        alm_sec_i,
    input  logic [7:0]        src_en_i,
    input  logic [3:0]        rate_log2_i,
    output logic [31:0]       cmp_o,
    output logic              chan_en_o,
    output logic [LOST_W-1:0] lost_o,
    output logic [15:0]       irq_word_o,
    output logic              irq_stb_o
);
    logic [TW-1:0]    delta;
    logic [LIM_W-1:0] limit;
    logic             any_src;
    logic             busy;
    logic             done;
    tod_t             now, alarm;

    assign any_src = |(src_en_i & (FLG_PER | FLG_ALM | FLG_UPD));
    assign now     = '{hour: hour_i, min: min_i, sec: sec_i};
    assign alarm   = '{hour: alm_hour_i, min: alm_min_i, sec: alm_sec_i};

    rtc_interval_sel #(.CNT_HZ(CNT_HZ)) u_sel (
        .per_en(src_en_i[6]), .rate_log2(rate_log2_i),
        .delta(delta), .limit(limit)
    );

    rtc_rearm #(.LOST_W(LOST_W)) u_rearm (
        .clk(clk), .rst(rst), .tick(tick_i), .count(count_i),
        .any_src(any_src), .delta(delta), .cmp(cmp_o),
        .chan_en(chan_en_o), .busy(busy), .done(done), .lost(lost_o)
    );

    rtc_flag_eval #(.LOST_W(LOST_W)) u_flags (
        .clk(clk), .rst(rst), .done(done), .lost(lost_o),
        .src_en(src_en_i), .now(now), .alarm(alarm), .limit(limit),
        .word(irq_word_o), .stb(irq_stb_o)
    );
endmodule

// File: rtl/rtc_emu_checker.sv
module rtc_emu_checker (
    input logic        clk,
    input logic        rst,
    input logic        tick_i,
    input logic [31:0] count_i,
    input logic [31:0] cmp_o,
    input logic        chan_en_o,
    input logic [15:0] irq_word_o,
    input logic        irq_stb_o,
    input logic        busy,
    input logic        done,
    input logic        any_src,
    input logic [31:0] delta
);
    logic any_prev;
    always_ff @(posedge clk) begin
        if (rst) any_prev <= 1'b0;
        else     any_prev <= any_src;
    end

    a_r8_word_fmt: assert property (@(posedge clk) disable iff (rst)
        irq_stb_o |-> (irq_word_o[15:7] == 9'h003) && (irq_word_o[6:4] != 3'b0)
                      && (irq_word_o[3:0] == 4'h0));

    a_r8_stb_pulse: assert property (@(posedge clk) disable iff (rst)
        irq_stb_o |=> !irq_stb_o);

    a_r7_disable: assert property (@(posedge clk) disable iff (rst)
        (tick_i && chan_en_o && !busy && !any_src) |=> !chan_en_o);

    a_r7_arm: assert property (@(posedge clk) disable iff (rst)
        (!busy && !(tick_i && chan_en_o) && any_src && !any_prev)
        |=> chan_en_o && (cmp_o == $past(count_i + delta)));

    a_r6_ahead: assert property (@(posedge clk) disable iff (rst)
        (done && $stable(count_i)) |-> !($signed(count_i - cmp_o) > 0));
endmodule

bind rtc_emu_unit rtc_emu_checker u_chk (
    .clk(clk), .rst(rst), .tick_i(tick_i), .count_i(count_i),
    .cmp_o(cmp_o), .chan_en_o(chan_en_o), .irq_word_o(irq_word_o),
    .irq_stb_o(irq_stb_o), .busy(busy), .done(done),
    .any_src(any_src), .delta(delta)
);

// File: tb/test_rtc_emu_unit.sv
module test_rtc_emu_unit;
    localparam int HZ = 4096;
    localparam logic [31:0] DB = 32'(HZ / 64);

    logic clk = 1'b0, rst = 1'b1, tick = 1'b0;
    logic [31:0] cnt = '0;
    logic [7:0] hr = 0, mn = 0, sc = 0, ahr = 0, amn = 0, asc = 0, en = 0;
    logic [3:0] rk = 0;
    logic [31:0] cmp;
    logic chen, stb;
    logic [7:0] lost;
    logic [15:0] word;

    int total = 0, bad = 0;
    logic [31:0] exp_cmp;

    always #5 clk = ~clk;

    rtc_emu_unit #(.CNT_HZ(HZ)) i_rtc_emu_unit (
        .clk(clk), .rst(rst), .tick_i(tick), .count_i(cnt),
        .hour_i(hr), .min_i(mn), .sec_i(sc),
        .alm_hour_i(ahr), .alm_min_i(amn), .alm_sec_i(asc),
        .src_en_i(en), .rate_log2_i(rk), .cmp_o(cmp), .chan_en_o(chen),
        .lost_o(lost), .irq_word_o(word), .irq_stb_o(stb)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // one tick with the counter at c; d is the interval expected in force
    task automatic do_tick(input logic [31:0] c, input logic [31:0] d,
                           input logic [15:0] exp_w, input string req);
        logic [31:0] m; int l; logic seen; logic [15:0] w;
        m = exp_cmp + d; l = 0;
        while ($signed(c - m) > 0) begin m = m + d; l++; end
        seen = 0; w = 0;
        @(negedge clk); cnt = c; tick = 1;
        @(negedge clk); tick = 0;
        for (int i = 0; i < 14; i++) begin
            @(negedge clk);
            if (stb) begin seen = 1; w = word; end
        end
        chk({req, " cmp"}, cmp, m);
        chk({req, " lost"}, 32'(lost), 32'(l));
        chk({req, " word"}, {16'h0, (seen ? w : 16'h0)}, {16'h0, exp_w});
        exp_cmp = m;
    endtask

    task automatic arm(input logic [31:0] c, input logic [7:0] m, input logic [31:0] d);
        @(negedge clk); cnt = c; en = m;
        @(negedge clk);
        chk("R7 arm en", {31'h0, chen}, 32'h1);
        chk("R7 arm cmp", cmp, c + d);
        exp_cmp = c + d;
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst = 0;
        @(negedge clk);
        chk("R8 reset chen", {31'h0, chen}, 0);
        chk("R8 reset stb", {31'h0, stb}, 0);
        chk("R8 reset cmp", cmp, 0);
        chk("R8 reset word", {16'h0, word}, 0);

        // R1/R7: arm with update source, base interval
        arm(32'd1000, 8'h10, DB);
        sc = 5;
        do_tick(exp_cmp + DB, DB, 16'h0190, "R4 update on change");
        do_tick(exp_cmp + DB, DB, 16'h0000, "R4 no update same sec");
        sc = 6;
        do_tick(exp_cmp + DB, DB, 16'h0190, "R1 R4 second change");

        // R5 alarm only
        en = 8'h20; hr = 3; mn = 4; sc = 5; ahr = 3; amn = 4; asc = 5;
        do_tick(exp_cmp + DB, DB, 16'h01A0, "R5 alarm match");
        amn = 9;
        do_tick(exp_cmp + DB, DB, 16'h0000, "R5 alarm minute mismatch");

        // R6 late tick: three lost
        do_tick(exp_cmp + 3 * DB + 10, DB, 16'h0000, "R6 late tick");

        // R2 slow periodic k=4 (limit 4), lost credit
        en = 8'h40; rk = 4;
        do_tick(exp_cmp + DB, DB, 16'h0000, "R2 div 1");
        do_tick(exp_cmp + DB, DB, 16'h0000, "R2 div 2");
        do_tick(exp_cmp + DB, DB, 16'h0000, "R2 div 3");
        do_tick(exp_cmp + DB, DB, 16'h01C0, "R2 div fire");
        do_tick(exp_cmp + 2 * DB + 5, DB, 16'h0000, "R2 lost credit");
        do_tick(exp_cmp + DB, DB, 16'h01C0, "R2 fire after credit");

        // R3 fast periodic
        for (int k = 7; k <= 12; k++) begin
            rk = 4'(k);
            do_tick(exp_cmp + (32'(HZ) >> k), 32'(HZ) >> k, 16'h01C0, "R3 fast");
        end

        // R2 sweep of slow rates
        for (int k = 6; k >= 0; k--) begin
            rk = 4'(k);
            for (int i = 1; i <= (1 << (6 - k)); i++)
                do_tick(exp_cmp + DB, DB, (i == (1 << (6 - k))) ? 16'h01C0 : 16'h0000,
                        "R2 sweep");
        end

        // R7/R9: only non-source bits -> channel disabled on tick
        en = 8'h8F;
        @(negedge clk); cnt = exp_cmp; tick = 1;
        @(negedge clk); tick = 0;
        repeat (4) @(negedge clk);
        chk("R7 R9 disabled", {31'h0, chen}, 0);
        chk("R7 cmp held", cmp, exp_cmp);
        chk("R9 no strobe", {31'h0, stb}, 0);

        // R6 across 32-bit wrap, fast rate k=8
        rk = 8;
        arm(32'hFFFF_FFF0, 8'h40, 32'd16);
        do_tick(32'h0000_0025, 32'd16, 16'h01C0, "R6 wrap");

        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        bad++; total++;
        $display("FAIL watchdog actual=hung expected=done");
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule